// File: doc/BRIEF.md
# SMBus Host Register Front-End

This block is the byte-wide register file that software uses to drive an SMBus host controller. It sits on a small I/O bus and provides registers for status, control, command code, target address, two data bytes, block data and auxiliary options. It also holds a 32-byte block buffer with an internal index that advances on each block-data access. Software sets up a transaction, clears old status by writing the flags back as ones, and sets the start bit. The block then presents a transaction descriptor to a byte-level bus engine: address byte, command code, protocol and count, with direct access to the buffer.

When the engine reports completion, the block drops the busy flag. It then sets either the success flag or the matching error flag. For a block read it stores the returned byte count in data0, and software pops the bytes through the block-data register. A kill request aborts the engine. Reading the control register rewinds the buffer index so that software can restart a buffer walk.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register reads 0x00, status included.
- R2: Command (0x3), address (0x4), data0 (0x5) and data1 (0x6) read back the last byte written. Auxiliary control (0xD) keeps only bits [1:0], where bit1 selects 32-byte buffer mode and bit0 enables CRC. Its other bits read 0.
- R3: Control (0x2) reads back enable in bit7, last-byte in bit5, protocol in bits [4:2] and interrupt enable in bit0. Start (bit6) and kill (bit1) always read 0. Any control read sets the buffer index to 0.
- R4: A write to block data (0x7) stores the byte at the current index, then advances the index by one. The index stops at 31, so further writes overwrite entry 31.
- R5: A read of block data returns the entry at the current index and advances the index, with the same stop at 31.
- R6: A control write with bit6=1 and bit1=0 while idle produces a one-cycle engine start pulse after the write edge. Status bit0 (busy) is set in the same cycle. The descriptor outputs carry the address, command, protocol and data0 registers.
- R7: A start written while busy is ignored: no further start pulse is produced.
- R8: An engine done with no error clears busy and sets status bit1. If address bit0=1 and protocol=5, a count of at most 32 is stored in data0. For writes, data0 is left unchanged.
- R9: On such a read, a returned count above 32 sets status bit2 (device error), and data0 is left unchanged.
- R10: An engine device error sets status bit2, and a bus error alone sets status bit3. Device error takes precedence over bus error. Busy clears in either case. A done while idle is ignored.
- R11: A status write clears each of bits [4:1] written as 1 and keeps those written as 0. Busy is never changed by a status write.
- R12: A control write with bit1=1 while busy produces a one-cycle engine kill pulse. Busy clears and status bit4 (failed) is set in the cycle after the write. Kill while idle has no effect.
- R13: The engine can write buffer entries through its own port and read any entry combinationally. Bytes written by the engine are then readable through the block-data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 4 | Register offset |
| io_wr_i | input | 1 | Register write strobe |
| io_rd_i | input | 1 | Register read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data for io_addr_i (combinational) |
| eng_start_o | output | 1 | One-cycle transaction start |
| eng_kill_o | output | 1 | One-cycle abort |
| eng_addr_o | output | 8 | Address byte with direction bit |
| eng_cmd_o | output | 8 | Command code |
| eng_proto_o | output | 3 | Protocol select |
| eng_count_o | output | 8 | Byte count (data0) |
| eng_done_i | input | 1 | Engine finished |
| eng_dev_err_i | input | 1 | Device error with done |
| eng_bus_err_i | input | 1 | Bus error with done |
| eng_count_i | input | 8 | Count returned by a block read |
| eng_buf_we_i | input | 1 | Engine buffer write |
| eng_buf_idx_i | input | 5 | Engine buffer index |
| eng_buf_wdata_i | input | 8 | Engine buffer write data |
| eng_buf_rdata_o | output | 8 | Buffer entry at eng_buf_idx_i |

## Verification
The bench targets the index stop at 31. A design that wraps would overwrite entry 0 and return early bytes on the 33rd read. It checks that a control read rewinds the index, since a missing rewind shifts every popped byte. It sweeps the returned count across the 32 boundary, where an off-by-one either stores 33 or flags a legal 32. It also checks that write-one-to-clear leaves busy and the unwritten flags intact, and that starts, kills and dones arriving in the wrong state leave no pulse and no flag.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam logic [3:0] OFS_STS = 4'h0;
  localparam logic [3:0] OFS_CTL = 4'h2;
  localparam logic [3:0] OFS_CMD = 4'h3;
  localparam logic [3:0] OFS_ADR = 4'h4;
  localparam logic [3:0] OFS_D0  = 4'h5;
  localparam logic [3:0] OFS_D1  = 4'h6;
  localparam logic [3:0] OFS_BLK = 4'h7;
  localparam logic [3:0] OFS_AUX = 4'hD;

  localparam logic [2:0] PROTO_BLOCK = 3'd5;

  typedef struct packed {
    logic       pec_en;
    logic       last;
    logic [2:0] proto;
    logic       irq_en;
  } ctl_t;
endpackage

// File: rtl/smb_blkbuf.sv
module smb_blkbuf #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rewind_i,
  input  logic          step_i,
  input  logic          cpu_we_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic [IW-1:0] idx_o,
  input  logic          eng_we_i,
  input  logic [IW-1:0] eng_idx_i,
  input  logic [DW-1:0] eng_wdata_i,
  output logic [DW-1:0] eng_rdata_o
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (rewind_i) begin
      idx_q <= '0;
    end else if (step_i && idx_q != LAST) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  // cpu port wins a same-entry collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (eng_we_i) mem_q[eng_idx_i] <= eng_wdata_i;
      if (cpu_we_i) mem_q[idx_q] <= cpu_wdata_i;
    end
  end

  assign cpu_rdata_o = mem_q[idx_q];
  assign eng_rdata_o = mem_q[eng_idx_i];
  assign idx_o       = idx_q;
endmodule

// File: rtl/smb_status.sv
module smb_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       kill_i,
  input  logic       done_i,
  input  logic       dev_err_i,
  input  logic       bus_err_i,
  input  logic       cnt_bad_i,
  input  logic       clr_i,
  input  logic [7:0] clr_mask_i,
  output logic       busy_o,
  output logic [7:0] sts_o
);
  logic busy_q, intr_q, dev_q, bus_q, fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
    end else if (kill_i || done_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
    end
  end

  // clear first, new events override
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      intr_q <= 1'b0;
      dev_q  <= 1'b0;
      bus_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      if (clr_i) begin
        if (clr_mask_i[1]) intr_q <= 1'b0;
        if (clr_mask_i[2]) dev_q  <= 1'b0;
        if (clr_mask_i[3]) bus_q  <= 1'b0;
        if (clr_mask_i[4]) fail_q <= 1'b0;
      end
      if (kill_i) fail_q <= 1'b1;
      if (done_i) begin
        if (dev_err_i || cnt_bad_i) dev_q <= 1'b1;
        else if (bus_err_i)         bus_q <= 1'b1;
        else                        intr_q <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign sts_o  = {3'b000, fail_q, bus_q, dev_q, intr_q, busy_q};
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_pkg::*;
#(
  parameter int unsigned BUF_DEPTH = 32,
  localparam int unsigned IW = $clog2(BUF_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    io_addr_i,
  input  logic          io_wr_i,
  input  logic          io_rd_i,
  input  logic [7:0]    io_wdata_i,
  output logic [7:0]    io_rdata_o,
  output logic          eng_start_o,
  output logic          eng_kill_o,
  output logic [7:0]    eng_addr_o,
  output logic [7:0]    eng_cmd_o,
  output logic [2:0]    eng_proto_o,
  output logic [7:0]    eng_count_o,
  input  logic          eng_done_i,
  input  logic          eng_dev_err_i,
  input  logic          eng_bus_err_i,
  input  logic [7:0]    eng_count_i,
  input  logic          eng_buf_we_i,
  input  logic [IW-1:0] eng_buf_idx_i,
  input  logic [7:0]    eng_buf_wdata_i,
  output logic [7:0]    eng_buf_rdata_o
);
  ctl_t       ctl_q;
  logic [7:0] cmd_q, adr_q, d0_q, d1_q;
  logic [1:0] aux_q;
  logic       start_q, kill_q;

  logic          busy;
  logic [7:0]    sts;
  logic [IW-1:0] blk_idx;
  logic [7:0]    blk_rdata;

  logic wr_ctl, start_req, kill_req, done_ok, is_blk_rd, cnt_bad, d0_load;

  assign wr_ctl    = io_wr_i && io_addr_i == OFS_CTL;
  assign kill_req  = wr_ctl && io_wdata_i[1] && busy;
  assign start_req = wr_ctl && io_wdata_i[6] && !io_wdata_i[1] && !busy;
  assign done_ok   = eng_done_i && busy && !kill_req;
  assign is_blk_rd = adr_q[0] && ctl_q.proto == PROTO_BLOCK;
  assign cnt_bad   = is_blk_rd && eng_count_i > 8'(BUF_DEPTH);
  assign d0_load   = done_ok && is_blk_rd && !cnt_bad && !eng_dev_err_i && !eng_bus_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      cmd_q   <= '0;
      adr_q   <= '0;
      d0_q    <= '0;
      d1_q    <= '0;
      aux_q   <= '0;
      start_q <= 1'b0;
      kill_q  <= 1'b0;
    end else begin
      start_q <= start_req;
      kill_q  <= kill_req;
      if (io_wr_i) begin
        unique case (io_addr_i)
          OFS_CTL: ctl_q <= '{pec_en: io_wdata_i[7], last: io_wdata_i[5],
                              proto: io_wdata_i[4:2], irq_en: io_wdata_i[0]};
          OFS_CMD: cmd_q <= io_wdata_i;
          OFS_ADR: adr_q <= io_wdata_i;
          OFS_D0:  d0_q  <= io_wdata_i;
          OFS_D1:  d1_q  <= io_wdata_i;
          OFS_AUX: aux_q <= io_wdata_i[1:0];
          default: ;
        endcase
      end
      if (d0_load) d0_q <= eng_count_i;
    end
  end

  smb_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_req),
    .kill_i     (kill_req),
    .done_i     (done_ok),
    .dev_err_i  (eng_dev_err_i),
    .bus_err_i  (eng_bus_err_i),
    .cnt_bad_i  (cnt_bad),
    .clr_i      (io_wr_i && io_addr_i == OFS_STS),
    .clr_mask_i (io_wdata_i),
    .busy_o     (busy),
    .sts_o      (sts)
  );

  smb_blkbuf #(.DEPTH(BUF_DEPTH), .DW(8)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rewind_i    (io_rd_i && io_addr_i == OFS_CTL),
    .step_i      ((io_rd_i || io_wr_i) && io_addr_i == OFS_BLK),
    .cpu_we_i    (io_wr_i && io_addr_i == OFS_BLK),
    .cpu_wdata_i (io_wdata_i),
    .cpu_rdata_o (blk_rdata),
    .idx_o       (blk_idx),
    .eng_we_i    (eng_buf_we_i),
    .eng_idx_i   (eng_buf_idx_i),
    .eng_wdata_i (eng_buf_wdata_i),
    .eng_rdata_o (eng_buf_rdata_o)
  );

  always_comb begin
    unique case (io_addr_i)
      OFS_STS: io_rdata_o = sts;
      OFS_CTL: io_rdata_o = {ctl_q.pec_en, 1'b0, ctl_q.last, ctl_q.proto, 1'b0, ctl_q.irq_en};
      OFS_CMD: io_rdata_o = cmd_q;
      OFS_ADR: io_rdata_o = adr_q;
      OFS_D0:  io_rdata_o = d0_q;
      OFS_D1:  io_rdata_o = d1_q;
      OFS_BLK: io_rdata_o = blk_rdata;
      OFS_AUX: io_rdata_o = {6'b0, aux_q};
      default: io_rdata_o = 8'h00;
    endcase
  end

  assign eng_start_o = start_q;
  assign eng_kill_o  = kill_q;
  assign eng_addr_o  = adr_q;
  assign eng_cmd_o   = cmd_q;
  assign eng_proto_o = ctl_q.proto;
  assign eng_count_o = d0_q;
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk #(
  parameter int unsigned BUF_DEPTH = 32,
  localparam int unsigned IW = $clog2(BUF_DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    io_addr_i,
  input logic          io_wr_i,
  input logic          io_rd_i,
  input logic          eng_start_o,
  input logic          eng_kill_o,
  input logic          eng_done_i,
  input logic          busy_i,
  input logic          failed_i,
  input logic [IW-1:0] idx_i
);
  localparam logic [IW-1:0] LAST = IW'(BUF_DEPTH - 1);

  p_start_sets_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> busy_i);

  p_start_only_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> $past(!busy_i));

  p_done_clears_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && eng_done_i) |=> !busy_i);

  p_kill_effect_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_kill_o |-> (!busy_i && failed_i));

  p_ctl_rd_rewind_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && io_addr_i == 4'h2) |=> idx_i == '0);

  p_idx_hold_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((io_rd_i || io_wr_i) && io_addr_i == 4'h7 && idx_i == LAST) |=> idx_i == LAST);
endmodule

bind smb_host_regs smb_host_regs_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .io_addr_i   (io_addr_i),
  .io_wr_i     (io_wr_i),
  .io_rd_i     (io_rd_i),
  .eng_start_o (eng_start_o),
  .eng_kill_o  (eng_kill_o),
  .eng_done_i  (eng_done_i),
  .busy_i      (busy),
  .failed_i    (sts[4]),
  .idx_i       (blk_idx)
);

// File: tb/smb_host_regs_tb_top.sv
module smb_host_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] io_addr = '0;
  logic       io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic       eng_start, eng_kill;
  logic [7:0] eng_addr, eng_cmd, eng_count;
  logic [2:0] eng_proto;
  logic       eng_done = 1'b0, eng_dev_err = 1'b0, eng_bus_err = 1'b0;
  logic [7:0] eng_cnt_in = '0;
  logic       eng_we = 1'b0;
  logic [4:0] eng_idx = '0;
  logic [7:0] eng_wd = '0;
  logic [7:0] eng_rd;

  int n_chk = 0, n_err = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  smb_host_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .eng_start_o(eng_start), .eng_kill_o(eng_kill),
    .eng_addr_o(eng_addr), .eng_cmd_o(eng_cmd), .eng_proto_o(eng_proto),
    .eng_count_o(eng_count), .eng_done_i(eng_done),
    .eng_dev_err_i(eng_dev_err), .eng_bus_err_i(eng_bus_err),
    .eng_count_i(eng_cnt_in), .eng_buf_we_i(eng_we), .eng_buf_idx_i(eng_idx),
    .eng_buf_wdata_i(eng_wd), .eng_buf_rdata_o(eng_rd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(posedge clk); #1;
    io_rd = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, {24'b0, d}, {24'b0, exp});
  endtask

  task automatic eng_fin(input logic [7:0] c, input logic de, input logic be);
    @(negedge clk);
    eng_done = 1'b1; eng_cnt_in = c; eng_dev_err = de; eng_bus_err = be;
    @(posedge clk); #1;
    eng_done = 1'b0; eng_dev_err = 1'b0; eng_bus_err = 1'b0;
  endtask

  task automatic eng_put(input logic [4:0] i, input logic [7:0] d);
    @(negedge clk);
    eng_we = 1'b1; eng_idx = i; eng_wd = d;
    @(posedge clk); #1;
    eng_we = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) % 256);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d0_exp;
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    foreach (dut_i.io_addr_i[i]) ;
    rdchk("R1 sts", 4'h0, 8'h00);
    rdchk("R1 ctl", 4'h2, 8'h00);
    rdchk("R1 cmd", 4'h3, 8'h00);
    rdchk("R1 adr", 4'h4, 8'h00);
    rdchk("R1 d0",  4'h5, 8'h00);
    rdchk("R1 d1",  4'h6, 8'h00);
    rdchk("R1 aux", 4'hD, 8'h00);
    chk("R1 start", {31'b0, eng_start}, 0);

    // R2 full sweep of plain registers
    for (int v = 0; v < 256; v++) begin
      wr(4'h3, 8'(v)); rdchk("R2 cmd", 4'h3, 8'(v));
      wr(4'h6, 8'(255 - v)); rdchk("R2 d1", 4'h6, 8'(255 - v));
    end
    for (int v = 0; v < 256; v += 5) begin
      wr(4'h4, 8'(v)); rdchk("R2 adr", 4'h4, 8'(v));
      wr(4'h5, 8'(v)); rdchk("R2 d0", 4'h5, 8'(v));
      wr(4'hD, 8'(v)); rdchk("R2 aux", 4'hD, 8'(v & 3));
    end

    // R3 control readback, start/kill read 0
    wr(4'h2, 8'hBD); rdchk("R3 ctl", 4'h2, 8'hBD);
    wr(4'h2, 8'h21); rdchk("R3 ctl", 4'h2, 8'h21);

    // R4/R5 buffer walk with saturation
    rd(4'h2, rv);
    for (int i = 0; i < 40; i++) wr(4'h7, pat(i));
    rd(4'h2, rv);
    for (int i = 0; i < 34; i++)
      rdchk(i < 31 ? "R5 blk rd" : "R4 sat", 4'h7, i < 31 ? pat(i) : pat(39));
    // R3 rewind mid-walk
    rd(4'h2, rv);
    rdchk("R3 rewind", 4'h7, pat(0));
    rdchk("R5 step", 4'h7, pat(1));
    // R13 engine read port
    for (int k = 0; k < 32; k += 3) begin
      @(negedge clk); eng_idx = 5'(k); #1;
      chk("R13 eng rd", {24'b0, eng_rd}, {24'b0, k < 31 ? pat(k) : pat(39)});
    end

    // R6 start, R7 start while busy ignored
    wr(4'h0, 8'hFF);
    wr(4'h4, 8'hA1); wr(4'h3, 8'h5C); wr(4'h5, 8'h07);
    wr(4'h2, 8'h54);
    chk("R6 start pulse", {31'b0, eng_start}, 1);
    chk("R6 adr", {24'b0, eng_addr}, 32'hA1);
    chk("R6 cmd", {24'b0, eng_cmd}, 32'h5C);
    chk("R6 proto", {29'b0, eng_proto}, 5);
    chk("R6 count", {24'b0, eng_count}, 7);
    wr(4'h2, 8'h54);
    chk("R7 no restart", {31'b0, eng_start}, 0);
    rdchk("R6 busy", 4'h0, 8'h01);

    // R13 engine fills buffer, R8 read done
    for (int k = 0; k < 5; k++) eng_put(5'(k), 8'hC0 ^ 8'(k));
    eng_fin(8'd5, 1'b0, 1'b0);
    rdchk("R8 sts", 4'h0, 8'h02);
    rdchk("R8 d0", 4'h5, 8'd5);
    rd(4'h2, rv);
    for (int k = 0; k < 5; k++) rdchk("R13 pop", 4'h7, 8'hC0 ^ 8'(k));

    // R8/R9 count sweep across the limit
    d0_exp = 8'd5;
    for (int c = 0; c <= 40; c++) begin
      wr(4'h0, 8'hFF);
      wr(4'h2, 8'h54);
      eng_fin(8'(c), 1'b0, 1'b0);
      if (c <= 32) d0_exp = 8'(c);
      rdchk(c > 32 ? "R9 sts" : "R8 sts", 4'h0, c > 32 ? 8'h04 : 8'h02);
      rdchk(c > 32 ? "R9 d0" : "R8 d0", 4'h5, d0_exp);
    end

    // R8 write transaction leaves d0
    wr(4'h0, 8'hFF); wr(4'h4, 8'hA0); wr(4'h5, 8'h03); wr(4'h2, 8'h54);
    eng_fin(8'd40, 1'b0, 1'b0);
    rdchk("R8 wr sts", 4'h0, 8'h02);
    rdchk("R8 wr d0", 4'h5, 8'h03);

    // R10 errors
    wr(4'h0, 8'hFF); wr(4'h2, 8'h54); eng_fin(8'd0, 1'b0, 1'b1);
    rdchk("R10 bus", 4'h0, 8'h08);
    wr(4'h0, 8'hFF); wr(4'h2, 8'h54); eng_fin(8'd0, 1'b1, 1'b1);
    rdchk("R10 dev", 4'h0, 8'h04);
    eng_fin(8'd0, 1'b0, 1'b1);
    rdchk("R10 idle done", 4'h0, 8'h04);

    // R12 kill
    wr(4'h0, 8'hFF); wr(4'h2, 8'h54);
    wr(4'h2, 8'h02);
    chk("R12 kill pulse", {31'b0, eng_kill}, 1);
    rdchk("R12 sts", 4'h0, 8'h10);
    chk("R12 pulse one", {31'b0, eng_kill}, 0);
    wr(4'h2, 8'h02);
    chk("R12 idle kill", {31'b0, eng_kill}, 0);
    rdchk("R12 idle sts", 4'h0, 8'h10);

    // R11 write-one-to-clear
    wr(4'h2, 8'h54);
    wr(4'h0, 8'h01);
    rdchk("R11 busy kept", 4'h0, 8'h11);
    eng_fin(8'd0, 1'b0, 1'b1);
    rdchk("R11 pre", 4'h0, 8'h18);
    wr(4'h0, 8'h08); rdchk("R11 clr bus", 4'h0, 8'h10);
    wr(4'h0, 8'h00); rdchk("R11 clr none", 4'h0, 8'h10);
    wr(4'h0, 8'h10); rdchk("R11 clr fail", 4'h0, 8'h00);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule